// File: doc/BRIEF.md
# Start-up Reset Sequencer

This block keeps a microcontroller core held off while the supply, the oscillator and the clock multiplier settle. It watches a power-on event, a brown-out comparator flag, an external reset request, a watchdog timeout and a wake-from-sleep event. From these it runs an ordered chain of timed stages. Each stage is skipped by a rule of its own, based on what started the sequence and on the configuration inputs. The core is released only when the chain reaches its final state.

The power-up stage counts ticks of the internal slow RC clock. The oscillator settling stage counts external-oscillator cycles. The clock-multiplier lock stage counts RC ticks again. A brown-out must persist for a qualifying number of clock cycles before it acts. The external request passes a width filter that discards short pulses. A four-bit sticky record shows which causes have reset the core since firmware last cleared it.

The state code is brought out at the ports. Integration logic and tests can therefore see which stage is holding the core.

Top module: `startup_reset_sequencer`

## Requirements
- R1: While rst_n is low the sequencer enters the hold state (seq_state code 0), core_hold is 1 and cause_flags is 4'b0001 (bit 0 = power-on, bit 1 = brown-out, bit 2 = external, bit 3 = watchdog).
- R2: After a power-on or brown-out hold with pwrt_en=1, the sequencer stays in the power-up state (code 1) until PWRT_TICKS rc_tick pulses have been counted, and leaves on the following clock edge. With pwrt_en=0 the power-up state is never entered.
- R3: A wake_evt seen in the run state (code 4) never passes through the power-up state.
- R4: The oscillator settling state (code 2) lasts OST_CYCLES osc_tick pulses plus one clock. It is entered only when osc_mode[2]=0 (crystal/resonator codes 0 to 3), and only after a power-on or a wake. It is never entered after brown-out, external or watchdog resets.
- R5: With pll_en=1 the lock state (code 3) follows the oscillator stage (or the power-up stage when the oscillator stage is skipped) and lasts PLL_TICKS rc_tick pulses. With pll_en=0 it is skipped. It is not used after external or watchdog resets.
- R6: With bor_en=1, supply_low held for BOR_QUAL consecutive clocks sends the sequencer to hold on the next edge and sets cause bit 1. Shorter runs, or any run with bor_en=0, leave the state unchanged.
- R7: The sequencer remains in hold while a qualified brown-out persists, and enters the power-up state after recovery. A brown-out during the power-up state restarts its count from zero.
- R8: ext_rst_req held for EXT_FILT consecutive clocks forces hold and sets cause bit 2. Shorter pulses have no effect. After an external or watchdog hold the sequencer goes straight to run (code 4) without any timed stage.
- R9: A one-cycle wdt_evt forces hold on the next edge and sets cause bit 3.
- R10: Cause bits are sticky. A flag_clr pulse clears all four, and a cause set in the same cycle wins over the clear.
- R11: por_evt forces hold from any state, sets cause bit 0, and takes priority over brown-out, external, watchdog and wake in the same cycle. In that case only bit 0 is set.
- R12: core_hold is 1 in every state except run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_evt | input | 1 | Power-on event pulse |
| supply_low | input | 1 | Brown-out comparator: supply below threshold |
| bor_en | input | 1 | Enables brown-out detection |
| ext_rst_req | input | 1 | Raw external reset request, active high |
| wdt_evt | input | 1 | Watchdog timeout pulse |
| wake_evt | input | 1 | Wake-from-sleep pulse |
| osc_mode | input | 3 | Oscillator mode; bit 2 low selects a crystal/resonator mode |
| pwrt_en | input | 1 | Enables the power-up delay |
| pll_en | input | 1 | Enables the clock-multiplier lock delay |
| rc_tick | input | 1 | One-cycle tick from the internal RC clock |
| osc_tick | input | 1 | One-cycle tick per external oscillator cycle |
| flag_clr | input | 1 | Pulse that clears the cause record |
| core_hold | output | 1 | Holds the core in reset when high |
| seq_state | output | 3 | Current stage: 0 hold, 1 power-up, 2 oscillator, 3 lock, 4 run |
| cause_flags | output | 4 | Sticky reset-cause record |

## Verification
Suppose an internal stage counter is wrong, or a skip rule or the event priority is wrong. The fault appears on seq_state and core_hold on the first clock edge where the sequencer should have changed stage, or should have stayed in one. A wrong count therefore shows up as the state code changing one or more clocks early or late. A wrong skip shows as a stage code that should not appear, or a missing one. A bad cause record is visible on cause_flags one clock after the triggering event or clear pulse. For that reason, a cycle-by-cycle comparison against a behavioural model catches each of these at the edge where it first happens.

// File: rtl/srs_pkg.sv
// Package: shared state and origin encodings for the start-up reset sequencer.
// Assumes: the state code values are visible at the ports and must stay fixed.
package srs_pkg;

    typedef enum logic [2:0] {
        ST_HOLD = 3'd0,
        ST_PWRT = 3'd1,
        ST_OST  = 3'd2,
        ST_PLL  = 3'd3,
        ST_RUN  = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        ORG_POWER = 2'd0,
        ORG_BROWN = 2'd1,
        ORG_SOFT  = 2'd2,
        ORG_WAKE  = 2'd3
    } origin_t;

    localparam int CAUSE_W   = 4;
    localparam int CAUSE_POR = 0;
    localparam int CAUSE_BOR = 1;
    localparam int CAUSE_EXT = 2;
    localparam int CAUSE_WDT = 3;

endpackage

// File: rtl/srs_level_qualifier.sv
// Level qualifier: reports a level only after it has been present for LEN
// consecutive clocks while enabled; any gap restarts the run.
// Assumes: LEN >= 1; level_in is already synchronous to clk.
module srs_level_qualifier #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic level_in,
    output logic qualified
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LIM = CW'(LEN);

    logic [CW-1:0] run_cnt;

    // Count consecutive enabled clocks of the level, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (en && level_in) begin
            if (run_cnt != LIM) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;
        end
    end

    // Qualified once the run has lasted the full length.
    assign qualified = (run_cnt == LIM);

    // R6 and R8: a gap in the level removes the qualified output on the next edge.
    assert_gap_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && level_in) |=> !qualified);

    // R7: a qualified level that persists stays qualified.
    assert_persist_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (qualified && en && level_in) |=> qualified);

endmodule

// File: rtl/srs_tick_counter.sv
// Stage timer: counts tick pulses while its stage is active, stops at LIMIT,
// and is cleared whenever the stage is not active.
// Assumes: LIMIT >= 1; tick is a one-clock pulse synchronous to clk.
module srs_tick_counter #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] tick_cnt;

    // Advance on each tick of the active stage; restart from zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (!active) begin
            tick_cnt <= '0;
        end else if (tick && !done) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    // Stage complete once the full tick count is reached.
    assign done = (tick_cnt == LIM);

    // R7: leaving the stage clears the timer, so a re-entry starts from zero.
    assert_idle_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !done);

endmodule

// File: rtl/srs_cause_flags.sv
// Cause record: sticky bits set by reset causes, cleared by a firmware pulse.
// A set in the same cycle as a clear survives.
// Assumes: reset state records a power-on cause.
module srs_cause_flags
    import srs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] set_vec,
    input  logic               clr,
    output logic [CAUSE_W-1:0] flags
);
    localparam logic [CAUSE_W-1:0] RESET_FLAGS = CAUSE_W'(1) << CAUSE_POR;

    // Hold, clear or accumulate the cause bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= RESET_FLAGS;
        end else begin
            flags <= (clr ? '0 : flags) | set_vec;
        end
    end

    // R10: a clear with no new cause leaves the record empty.
    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (set_vec == '0)) |=> (flags == '0));

    // R10: every requested cause is recorded on the next edge.
    assert_set_recorded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/startup_reset_sequencer.sv
// Start-up reset sequencer: holds the core through a power-up delay,
// an oscillator settling delay and a clock-multiplier lock delay, skipping
// each by its own rule. The rules depend on the cause of the sequence.
// Event priority: power-on, brown-out, external, watchdog, wake.
// Assumes: all event, tick and comparator inputs are synchronous to clk.
module startup_reset_sequencer
    import srs_pkg::*;
#(
    parameter int PWRT_TICKS = 2048,
    parameter int OST_CYCLES = 1024,
    parameter int PLL_TICKS  = 64,
    parameter int BOR_QUAL   = 32,
    parameter int EXT_FILT   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_evt,
    input  logic               supply_low,
    input  logic               bor_en,
    input  logic               ext_rst_req,
    input  logic               wdt_evt,
    input  logic               wake_evt,
    input  logic [2:0]         osc_mode,
    input  logic               pwrt_en,
    input  logic               pll_en,
    input  logic               rc_tick,
    input  logic               osc_tick,
    input  logic               flag_clr,
    output logic               core_hold,
    output logic [2:0]         seq_state,
    output logic [CAUSE_W-1:0] cause_flags
);

    seq_state_t state_q, state_d;
    origin_t    origin_q, origin_d;
    logic [CAUSE_W-1:0] cause_set;
    logic bor_hold, ext_hold;
    logic pwrt_done, ost_done, pll_done;
    logic xtal_mode;

    assign xtal_mode = ~osc_mode[2];

    // Brown-out must persist for the qualifying time before it acts.
    srs_level_qualifier #(.LEN(BOR_QUAL)) u_bor_qual (
        .clk(clk), .rst_n(rst_n), .en(bor_en),
        .level_in(supply_low), .qualified(bor_hold)
    );

    // External request width filter.
    srs_level_qualifier #(.LEN(EXT_FILT)) u_ext_filt (
        .clk(clk), .rst_n(rst_n), .en(1'b1),
        .level_in(ext_rst_req), .qualified(ext_hold)
    );

    // Power-up delay on RC ticks.
    srs_tick_counter #(.LIMIT(PWRT_TICKS)) u_pwrt_cnt (
        .clk(clk), .rst_n(rst_n), .active(state_q == ST_PWRT),
        .tick(rc_tick), .done(pwrt_done)
    );

    // Oscillator settling delay on external oscillator cycles.
    srs_tick_counter #(.LIMIT(OST_CYCLES)) u_ost_cnt (
        .clk(clk), .rst_n(rst_n), .active(state_q == ST_OST),
        .tick(osc_tick), .done(ost_done)
    );

    // Clock-multiplier lock delay on RC ticks.
    srs_tick_counter #(.LIMIT(PLL_TICKS)) u_pll_cnt (
        .clk(clk), .rst_n(rst_n), .active(state_q == ST_PLL),
        .tick(rc_tick), .done(pll_done)
    );

    // Stage that follows the oscillator stage.
    function automatic seq_state_t after_osc(input logic pll_on);
        return pll_on ? ST_PLL : ST_RUN;
    endfunction

    // Stage that follows the power-up stage for a given origin.
    function automatic seq_state_t after_pwrt(input origin_t org, input logic xtal,
                                              input logic pll_on);
        if (xtal && (org == ORG_POWER || org == ORG_WAKE)) return ST_OST;
        return after_osc(pll_on);
    endfunction

    // First stage entered when leaving hold.
    function automatic seq_state_t first_stage(input origin_t org, input logic pwrt_on,
                                               input logic xtal, input logic pll_on);
        if (org == ORG_SOFT) return ST_RUN;
        if (pwrt_on && org != ORG_WAKE) return ST_PWRT;
        return after_pwrt(org, xtal, pll_on);
    endfunction

    // Next-state, origin and cause selection, in event priority order.
    always_comb begin
        state_d   = state_q;
        origin_d  = origin_q;
        cause_set = '0;
        if (por_evt) begin
            state_d = ST_HOLD;
            origin_d = ORG_POWER;
            cause_set[CAUSE_POR] = 1'b1;
        end else if (bor_hold) begin
            state_d = ST_HOLD;
            origin_d = ORG_BROWN;
            cause_set[CAUSE_BOR] = 1'b1;
        end else if (ext_hold) begin
            state_d = ST_HOLD;
            origin_d = ORG_SOFT;
            cause_set[CAUSE_EXT] = 1'b1;
        end else if (wdt_evt) begin
            state_d = ST_HOLD;
            origin_d = ORG_SOFT;
            cause_set[CAUSE_WDT] = 1'b1;
        end else if (wake_evt && state_q == ST_RUN) begin
            origin_d = ORG_WAKE;
            state_d = after_pwrt(ORG_WAKE, xtal_mode, pll_en);
        end else begin
            unique case (state_q)
                ST_HOLD: state_d = first_stage(origin_q, pwrt_en, xtal_mode, pll_en);
                ST_PWRT: if (pwrt_done) state_d = after_pwrt(origin_q, xtal_mode, pll_en);
                ST_OST:  if (ost_done)  state_d = after_osc(pll_en);
                ST_PLL:  if (pll_done)  state_d = ST_RUN;
                ST_RUN:  state_d = ST_RUN;
                default: state_d = ST_HOLD;
            endcase
        end
    end

    // Sequencer state and origin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_HOLD;
            origin_q <= ORG_POWER;
        end else begin
            state_q  <= state_d;
            origin_q <= origin_d;
        end
    end

    // Sticky record of reset causes.
    srs_cause_flags u_causes (
        .clk(clk), .rst_n(rst_n), .set_vec(cause_set),
        .clr(flag_clr), .flags(cause_flags)
    );

    assign core_hold = (state_q != ST_RUN);
    assign seq_state = state_q;

    // R2: the power-up stage is left for a later stage only after its full count.
    assert_pwrt_complete_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q == ST_PWRT) && state_q != ST_PWRT && state_q != ST_HOLD)
        |-> $past(pwrt_done));

    // R4: the oscillator stage is left for a later stage only after its full count.
    assert_ost_complete_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q == ST_OST) && state_q != ST_OST && state_q != ST_HOLD)
        |-> $past(ost_done));

    // R5: the lock stage is left for run only after its full count.
    assert_pll_complete_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q == ST_PLL) && state_q == ST_RUN) |-> $past(pll_done));

    // R6: a qualified brown-out holds the core on the next edge.
    assert_brownout_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bor_hold |=> (state_q == ST_HOLD));

    // R8: a filtered external request holds the core on the next edge.
    assert_ext_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_hold |=> (state_q == ST_HOLD));

    // R11: power-on wins and records a power-on origin.
    assert_por_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
        por_evt |=> (state_q == ST_HOLD && origin_q == ORG_POWER));

    // R3: a wake from run never enters the power-up stage.
    assert_wake_skips_pwrt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wake_evt && !por_evt && !bor_hold && !ext_hold && !wdt_evt)
        |=> (state_q != ST_PWRT));

endmodule

// File: tb/test_startup_reset_sequencer.sv
`timescale 1ns/1ps
module test_startup_reset_sequencer;

    localparam int PWRT_T = 20;
    localparam int OST_C  = 1024;
    localparam int PLL_T  = 10;
    localparam int BOR_Q  = 4;
    localparam int EXT_F  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_evt = 0, supply_low = 0, bor_en = 1, ext_rst_req = 0, wdt_evt = 0;
    logic wake_evt = 0, pwrt_en = 1, pll_en = 1, rc_tick = 0, osc_tick = 0, flag_clr = 0;
    logic [2:0] osc_mode = 3'd0;
    logic core_hold;
    logic [2:0] seq_state;
    logic [3:0] cause_flags;

    int checks = 0;
    int errors = 0;
    int tcount = 0;
    int cnt_pwrt = 0, cnt_ost = 0, cnt_pll = 0;

    // Reference model variables.
    int m_state = 0, m_org = 0, m_flags = 1;
    int m_bq = 0, m_eq = 0, m_pw = 0, m_os = 0, m_pl = 0;

    always #4 clk = ~clk;

    startup_reset_sequencer #(
        .PWRT_TICKS(PWRT_T), .OST_CYCLES(OST_C), .PLL_TICKS(PLL_T),
        .BOR_QUAL(BOR_Q), .EXT_FILT(EXT_F)
    ) i_startup_reset_sequencer (
        .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .supply_low(supply_low),
        .bor_en(bor_en), .ext_rst_req(ext_rst_req), .wdt_evt(wdt_evt),
        .wake_evt(wake_evt), .osc_mode(osc_mode), .pwrt_en(pwrt_en),
        .pll_en(pll_en), .rc_tick(rc_tick), .osc_tick(osc_tick),
        .flag_clr(flag_clr), .core_hold(core_hold), .seq_state(seq_state),
        .cause_flags(cause_flags)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural model: origin 0 power, 1 brown, 2 soft, 3 wake.
    function automatic int stage_after_pwrt(int org);
        if (osc_mode < 3'd4 && (org == 0 || org == 3)) return 2;
        return pll_en ? 3 : 4;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_org = 0; m_flags = 1;
            m_bq = 0; m_eq = 0; m_pw = 0; m_os = 0; m_pl = 0;
        end else begin
            bit bh, eh, pwd, osd, pld;
            int nxt, set;
            bh = (m_bq == BOR_Q); eh = (m_eq == EXT_F);
            pwd = (m_pw == PWRT_T); osd = (m_os == OST_C); pld = (m_pl == PLL_T);
            nxt = m_state; set = 0;
            if (por_evt) begin nxt = 0; m_org = 0; set = 1; end
            else if (bh) begin nxt = 0; m_org = 1; set = 2; end
            else if (eh) begin nxt = 0; m_org = 2; set = 4; end
            else if (wdt_evt) begin nxt = 0; m_org = 2; set = 8; end
            else if (wake_evt && m_state == 4) begin m_org = 3; nxt = stage_after_pwrt(3); end
            else begin
                case (m_state)
                    0: begin
                        if (m_org == 2) nxt = 4;
                        else if (pwrt_en && m_org != 3) nxt = 1;
                        else nxt = stage_after_pwrt(m_org);
                    end
                    1: if (pwd) nxt = stage_after_pwrt(m_org);
                    2: if (osd) nxt = pll_en ? 3 : 4;
                    3: if (pld) nxt = 4;
                    default: nxt = m_state;
                endcase
            end
            m_bq = (supply_low && bor_en) ? ((m_bq < BOR_Q) ? m_bq + 1 : m_bq) : 0;
            m_eq = ext_rst_req ? ((m_eq < EXT_F) ? m_eq + 1 : m_eq) : 0;
            if (m_state != 1) m_pw = 0; else if (rc_tick && !pwd) m_pw++;
            if (m_state != 2) m_os = 0; else if (osc_tick && !osd) m_os++;
            if (m_state != 3) m_pl = 0; else if (rc_tick && !pld) m_pl++;
            if (flag_clr) m_flags = 0;
            m_flags = m_flags | set;
            m_state = nxt;
        end
    end

    // Per-cycle comparison against the model and stage occupancy counts.
    always @(negedge clk) begin
        if (rst_n) begin
            string tg;
            case (m_state)
                0: tg = "R6"; 1: tg = "R2"; 2: tg = "R4"; 3: tg = "R5"; default: tg = "R8";
            endcase
            chk(int'(seq_state) == m_state, tg, seq_state, m_state);
            chk(int'(cause_flags) == m_flags, "R10", cause_flags, m_flags);
            chk(core_hold == (m_state != 4), "R12", core_hold, m_state != 4);
            if (seq_state == 3'd1) cnt_pwrt++;
            if (seq_state == 3'd2) cnt_ost++;
            if (seq_state == 3'd3) cnt_pll++;
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rc_tick = (tcount % 3 == 0);
            osc_tick = 1'b1;
            tcount++;
        end
    endtask

    task automatic clear_counts();
        cnt_pwrt = 0; cnt_ost = 0; cnt_pll = 0;
    endtask

    task automatic wait_run(input string tag);
        bit got;
        got = 0;
        for (int i = 0; i < 5000; i++) begin
            cyc(1);
            if (seq_state == 3'd4) begin got = 1; break; end
        end
        chk(got, tag, seq_state, 4);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1; cyc(1); sig = 1'b0;
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(4);
        chk(seq_state == 3'd0, "R1 state", seq_state, 0);
        chk(core_hold == 1'b1, "R1 hold", core_hold, 1);
        chk(cause_flags == 4'b0001, "R1 flags", cause_flags, 1);
        rst_n = 1'b1;
        clear_counts();
        wait_run("R2 power-on reaches run");
        chk(cnt_pwrt >= 3*PWRT_T-1 && cnt_pwrt <= 3*PWRT_T+1, "R2 pwrt length", cnt_pwrt, 3*PWRT_T);
        chk(cnt_ost == OST_C + 1, "R4 ost length", cnt_ost, OST_C + 1);
        chk(cnt_pll >= 3*PLL_T-1 && cnt_pll <= 3*PLL_T+1, "R5 pll length", cnt_pll, 3*PLL_T);

        pulse(flag_clr); cyc(1);
        chk(cause_flags == 4'b0000, "R10 clear", cause_flags, 0);

        supply_low = 1; cyc(BOR_Q - 1); supply_low = 0; cyc(3);
        chk(seq_state == 3'd4, "R6 short dip ignored", seq_state, 4);
        bor_en = 0; supply_low = 1; cyc(10); supply_low = 0; bor_en = 1; cyc(2);
        chk(seq_state == 3'd4, "R6 disabled ignored", seq_state, 4);

        supply_low = 1; cyc(12);
        chk(seq_state == 3'd0, "R6 brown-out hold", seq_state, 0);
        chk(cause_flags[1] == 1'b1, "R6 brown flag", cause_flags[1], 1);
        clear_counts(); supply_low = 0; cyc(4);
        chk(seq_state == 3'd1, "R7 recovery enters pwrt", seq_state, 1);
        wait_run("R7 brown-out recovery");
        chk(cnt_ost == 0, "R4 no ost after brown-out", cnt_ost, 0);

        supply_low = 1; cyc(8); supply_low = 0; cyc(30);
        supply_low = 1; cyc(6); supply_low = 0;
        chk(seq_state == 3'd0, "R7 brown-out during pwrt", seq_state, 0);
        clear_counts();
        wait_run("R7 restart completes");
        chk(cnt_pwrt >= 3*PWRT_T-1 && cnt_pwrt <= 3*PWRT_T+1, "R7 pwrt restarted", cnt_pwrt, 3*PWRT_T);

        pulse(flag_clr);
        ext_rst_req = 1; cyc(EXT_F - 1); ext_rst_req = 0; cyc(2);
        chk(seq_state == 3'd4, "R8 short ext ignored", seq_state, 4);
        chk(cause_flags == 4'b0000, "R8 no ext flag", cause_flags, 0);
        clear_counts();
        ext_rst_req = 1; cyc(EXT_F + 2); ext_rst_req = 0;
        chk(cause_flags[2] == 1'b1, "R8 ext flag", cause_flags[2], 1);
        wait_run("R8 ext release");
        chk(cnt_pwrt + cnt_ost + cnt_pll == 0, "R8 no timed stage", cnt_pwrt + cnt_ost + cnt_pll, 0);

        pulse(wdt_evt);
        chk(seq_state == 3'd0, "R9 watchdog hold", seq_state, 0);
        chk(cause_flags[3] == 1'b1, "R9 watchdog flag", cause_flags[3], 1);
        wait_run("R9 watchdog release");

        clear_counts();
        pulse(wake_evt);
        wait_run("R3 wake completes");
        chk(cnt_pwrt == 0, "R3 wake skips pwrt", cnt_pwrt, 0);
        chk(cnt_ost == OST_C + 1, "R4 ost on wake", cnt_ost, OST_C + 1);

        osc_mode = 3'd5; pwrt_en = 0; clear_counts();
        pulse(por_evt);
        chk(seq_state == 3'd0, "R11 por hold", seq_state, 0);
        chk(cause_flags[0] == 1'b1, "R11 por flag", cause_flags[0], 1);
        wait_run("R11 por completes");
        chk(cnt_pwrt == 0, "R2 pwrt bypassed", cnt_pwrt, 0);
        chk(cnt_ost == 0, "R4 no ost in clock mode", cnt_ost, 0);
        chk(cnt_pll > 0, "R5 pll used", cnt_pll, 1);

        pll_en = 0; clear_counts();
        pulse(por_evt);
        wait_run("R5 no pll completes");
        chk(cnt_pll == 0, "R5 pll skipped", cnt_pll, 0);

        pulse(flag_clr);
        por_evt = 1; wdt_evt = 1; cyc(1); por_evt = 0; wdt_evt = 0; cyc(1);
        chk(cause_flags == 4'b0001, "R11 priority", cause_flags, 1);
        wait_run("R11 priority completes");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule